// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block produces the column address of every data beat in one burst of a double-data-rate memory. A burst is launched by a one-cycle start strobe that carries the first column, a burst-length code and an ordering bit. Data moves on both clock edges, so two beats share each clock cycle. The block therefore delivers one pair of addresses per clock: a lead address and a trail address. The burst takes BL/2 clock cycles, and the cycle that carries the final pair raises a last flag.

Two wrap orderings are supported. In sequential order the low log2(BL) column bits count upward from the start column and wrap inside the aligned block of BL columns. In interleaved order those low bits are the start column XORed with the beat index. In both orders the column bits above the burst block are held. A new start strobe always wins, even in the middle of a burst, and the sequence restarts from the new column.

Top module: `ddr_burst_col_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, `valid_o` and `last_o` are 0.
- R2: A start sampled on a rising edge makes `valid_o` 1 in the following cycle, with `col_lead_o` equal to the start column.
- R3: `bl_code_i` selects the burst length as 2 to the power of the code: 1 gives 2 beats, 2 gives 4 and 3 gives 8. Code 0 is treated as 2 beats. A burst stays valid for exactly BL/2 cycles.
- R4: When `ilv_i` is 0, beat b carries the start column with its low log2(BL) bits replaced by (start + b) mod BL. All higher bits are kept.
- R5: When `ilv_i` is 1, beat b carries the start column with its low log2(BL) bits replaced by (start XOR b). All higher bits are kept.
- R6: The start column, length code and ordering bit are sampled only with a start. Changes to them at any other time have no effect on the outputs.
- R7: In the p-th cycle of a burst (p counting from 0), `col_lead_o` carries beat 2p and `col_trail_o` carries beat 2p+1.
- R8: `last_o` is 1 only in the cycle that carries the final pair. Without a new start, `valid_o` is 0 in the cycle after that.
- R9: A start sampled during a burst abandons it. The next cycle carries the first pair of the new burst.
- R10: A start sampled in the last cycle of a burst is followed at once by the first pair of the new burst, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; launches a burst |
| col_i | input | COL_W | Start column, sampled with the strobe |
| bl_code_i | input | CODE_W | Burst-length code: BL = 2^code, with code 0 treated as 1 |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| valid_o | output | 1 | A pair of beat addresses is present |
| col_lead_o | output | COL_W | Address of the first beat of the pair |
| col_trail_o | output | COL_W | Address of the second beat of the pair |
| last_o | output | 1 | This pair is the final one of the burst |

## Verification
The hardest cases to reach from the ports are a restart: one that cuts a burst short partway through, and one that lands exactly in the last cycle of a burst. In both, the counter reset and the last-flag decode compete at the same edge. The stimulus times a second strobe against the first burst's cycle count for both cases and checks that the new pair appears at once. Every table burst also scrambles the column, length and ordering inputs right after its strobe, to prove that only the sampled values steer the sequence.

// File: rtl/ddr_bseq_pkg.sv
package ddr_bseq_pkg;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;

   // Map a raw length code to log2 of the burst length, clamped to [1, max_log].
   function automatic int unsigned clamp_bl_log(input int unsigned code,
                                                input int unsigned max_log);
      if (code == 0)            return 1;
      else if (code > max_log)  return max_log;
      else                      return code;
   endfunction

endpackage

// File: rtl/bseq_mode_latch.sv
module bseq_mode_latch
   import ddr_bseq_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter int CODE_W  = 2,
   parameter int MAX_LOG = 3,
   parameter int LOG_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [CODE_W-1:0] bl_code_i,
   input  logic              ilv_i,
   output logic [COL_W-1:0]  col_q_o,
   output order_e            order_o,
   output logic [LOG_W-1:0]  bl_log_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q_o  <= '0;
         order_o  <= ORD_SEQ;
         bl_log_o <= LOG_W'(1);
      end else if (start_i) begin
         col_q_o  <= col_i;
         order_o  <= ilv_i ? ORD_ILV : ORD_SEQ;
         bl_log_o <= LOG_W'(clamp_bl_log(32'(bl_code_i), MAX_LOG));
      end
   end

endmodule

// File: rtl/bseq_pair_ctr.sv
module bseq_pair_ctr #(
   parameter int PAIR_W = 2,
   parameter int LOG_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LOG_W-1:0]  bl_log_i,
   output logic              active_o,
   output logic [PAIR_W-1:0] pair_o,
   output logic              last_o
);

   logic [PAIR_W-1:0] last_pair;
   logic [31:0]       shamt;
   logic              at_end;

   always_comb begin
      shamt     = 32'(bl_log_i) - 32'd1;
      last_pair = PAIR_W'((32'd1 << shamt) - 32'd1);
   end

   assign at_end = (pair_o == last_pair);
   assign last_o = active_o && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         pair_o   <= '0;
      end else if (start_i) begin
         active_o <= 1'b1;
         pair_o   <= '0;
      end else if (active_o) begin
         if (at_end) begin
            active_o <= 1'b0;
            pair_o   <= '0;
         end else begin
            pair_o   <= pair_o + 1'b1;
         end
      end
   end

   AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> pair_o <= last_pair);                        // R3

   AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      active_o && !last_o && !start_i |=> active_o && pair_o == $past(pair_o) + 1'b1); // R7

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
   import ddr_bseq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int LOG_W  = 2,
   parameter int PAIR_W = 2,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0]  col_i,
   input  order_e            order_i,
   input  logic [LOG_W-1:0]  bl_log_i,
   input  logic [PAIR_W-1:0] pair_i,
   output logic [COL_W-1:0]  lead_o,
   output logic [COL_W-1:0]  trail_o
);

   localparam int LANES = 2;

   logic [COL_W-1:0] wrap_mask;
   logic [COL_W-1:0] lane_addr [LANES];

   assign wrap_mask = COL_W'((32'd1 << bl_log_i) - 32'd1);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [COL_W-1:0] beat_idx;
      logic [COL_W-1:0] seq_low;
      logic [COL_W-1:0] alt_low;

      assign beat_idx = COL_W'({pair_i, 1'(l)});
      assign seq_low  = (col_i + beat_idx) & wrap_mask;

      if (ILV_EN) begin : g_ilv
         assign alt_low = (col_i ^ beat_idx) & wrap_mask;
      end else begin : g_seq_only
         assign alt_low = seq_low;
      end

      assign lane_addr[l] = (col_i & ~wrap_mask)
                          | ((order_i == ORD_ILV) ? alt_low : seq_low);
   end

   assign lead_o  = lane_addr[0];
   assign trail_o = lane_addr[1];

endmodule

// File: rtl/ddr_burst_col_seq.sv
module ddr_burst_col_seq
   import ddr_bseq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MAX_BL = 8,
   parameter int CODE_W = 2,
   parameter bit ILV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [CODE_W-1:0] bl_code_i,
   input  logic              ilv_i,
   output logic              valid_o,
   output logic [COL_W-1:0]  col_lead_o,
   output logic [COL_W-1:0]  col_trail_o,
   output logic              last_o
);

   localparam int MAX_LOG = $clog2(MAX_BL);
   localparam int LOG_W   = $clog2(MAX_LOG + 1);
   localparam int PAIR_W  = (MAX_LOG > 1) ? MAX_LOG - 1 : 1;

   if (MAX_BL < 2 || (MAX_BL & (MAX_BL - 1)) != 0) begin : g_bad_bl
      $error("MAX_BL must be a power of two of at least 2");
   end
   if (COL_W <= MAX_LOG) begin : g_bad_col
      $error("COL_W must exceed log2(MAX_BL)");
   end
   if ((1 << CODE_W) <= MAX_LOG) begin : g_bad_code
      $error("CODE_W too narrow to select MAX_BL");
   end

   logic [COL_W-1:0]  col_q;
   order_e            order_q;
   logic [LOG_W-1:0]  bl_log_q;
   logic [PAIR_W-1:0] pair_q;

   bseq_mode_latch #(
      .COL_W   (COL_W),
      .CODE_W  (CODE_W),
      .MAX_LOG (MAX_LOG),
      .LOG_W   (LOG_W)
   ) i_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .col_i     (col_i),
      .bl_code_i (bl_code_i),
      .ilv_i     (ilv_i),
      .col_q_o   (col_q),
      .order_o   (order_q),
      .bl_log_o  (bl_log_q)
   );

   bseq_pair_ctr #(
      .PAIR_W (PAIR_W),
      .LOG_W  (LOG_W)
   ) i_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .bl_log_i (bl_log_q),
      .active_o (valid_o),
      .pair_o   (pair_q),
      .last_o   (last_o)
   );

   bseq_addr_gen #(
      .COL_W  (COL_W),
      .LOG_W  (LOG_W),
      .PAIR_W (PAIR_W),
      .ILV_EN (ILV_EN)
   ) i_addr (
      .col_i    (col_q),
      .order_i  (order_q),
      .bl_log_i (bl_log_q),
      .pair_i   (pair_q),
      .lead_o   (col_lead_o),
      .trail_o  (col_trail_o)
   );

   AST_LEAD_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o && col_lead_o == $past(col_i));       // R2

   AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);                                      // R8

   AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !start_i |=> !valid_o);                         // R8

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !start_i |=> !valid_o || $stable(col_lead_o[COL_W-1:MAX_LOG])); // R4

   AST_PAIR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> col_trail_o[COL_W-1:MAX_LOG] == col_lead_o[COL_W-1:MAX_LOG]); // R7

   AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && valid_o |=> valid_o);                          // R9

endmodule

// File: tb/test_ddr_burst_col_seq.sv
`timescale 1ns/1ps
module test_ddr_burst_col_seq;

   localparam int COL_W = 10;
   localparam int NV    = 8;

   // {expected cycles[2:0], ilv, code[1:0], column[9:0]}
   localparam logic [15:0] VEC [NV] = '{
      {3'd4, 1'b0, 2'd3, 10'h2A5},
      {3'd4, 1'b1, 2'd3, 10'h2A5},
      {3'd2, 1'b0, 2'd2, 10'h013},
      {3'd2, 1'b1, 2'd2, 10'h013},
      {3'd1, 1'b0, 2'd1, 10'h3FF},
      {3'd1, 1'b1, 2'd0, 10'h100},
      {3'd4, 1'b1, 2'd3, 10'h0C6},
      {3'd2, 1'b0, 2'd2, 10'h001}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] col_i = '0;
   logic [1:0]       bl_code_i = '0;
   logic             ilv_i = 1'b0;
   logic             valid_o;
   logic [COL_W-1:0] col_lead_o;
   logic [COL_W-1:0] col_trail_o;
   logic             last_o;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   ddr_burst_col_seq i_ddr_burst_col_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .col_i       (col_i),
      .bl_code_i   (bl_code_i),
      .ilv_i       (ilv_i),
      .valid_o     (valid_o),
      .col_lead_o  (col_lead_o),
      .col_trail_o (col_trail_o),
      .last_o      (last_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [COL_W-1:0] model(input logic [COL_W-1:0] col,
                                              input logic [1:0] code,
                                              input logic ilv, input int b);
      int               bl;
      logic [COL_W-1:0] m;
      logic [COL_W-1:0] low;
      bl  = (code == 2'd0) ? 2 : (1 << code);
      m   = COL_W'(bl - 1);
      low = ilv ? ((col ^ COL_W'(b)) & m) : ((col + COL_W'(b)) & m);
      return (col & ~m) | low;
   endfunction

   task automatic check_pair(input logic [COL_W-1:0] col, input logic [1:0] code,
                             input logic ilv, input int p, input int ncyc);
      chk("R3 valid during burst", 32'(valid_o), 32'd1);
      chk(ilv ? "R5 R6 interleaved lead" : "R4 R6 sequential lead",
          32'(col_lead_o), 32'(model(col, code, ilv, 2 * p)));
      chk("R7 trail beat", 32'(col_trail_o), 32'(model(col, code, ilv, 2 * p + 1)));
      chk("R8 last flag", 32'(last_o), 32'(p == ncyc - 1));
   endtask

   task automatic launch(input logic [COL_W-1:0] col, input logic [1:0] code, input logic ilv);
      start_i   = 1'b1;
      col_i     = col;
      bl_code_i = code;
      ilv_i     = ilv;
      @(posedge clk);
      @(negedge clk);
      // R6: scramble the mode inputs once the strobe has been taken
      start_i   = 1'b0;
      col_i     = ~col;
      bl_code_i = code + 2'd1;
      ilv_i     = ~ilv;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [15:0]      e;
      logic [COL_W-1:0] c;
      logic [1:0]       k;
      logic             il;
      int               n;

      repeat (3) @(negedge clk);
      chk("R1 valid in reset", 32'(valid_o), 32'd0);
      chk("R1 last in reset", 32'(last_o), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 valid idle", 32'(valid_o), 32'd0);

      // Table walk: R2 R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         e  = VEC[v];
         c  = e[9:0];
         k  = e[11:10];
         il = e[12];
         n  = int'(e[15:13]);
         launch(c, k, il);
         chk("R2 lead equals start", 32'(col_lead_o), 32'(c));
         for (int p = 0; p < n; p++) begin
            check_pair(c, k, il, p, n);
            @(negedge clk);
         end
         chk("R3 R8 valid drops after burst", 32'(valid_o), 32'd0);
         @(negedge clk);
      end

      // R9: restart an 8-beat burst after two pairs
      launch(10'h2A5, 2'd3, 1'b0);
      check_pair(10'h2A5, 2'd3, 1'b0, 0, 4);
      @(negedge clk);
      check_pair(10'h2A5, 2'd3, 1'b0, 1, 4);
      launch(10'h013, 2'd2, 1'b1);
      chk("R9 restart lead", 32'(col_lead_o), 32'h013);
      check_pair(10'h013, 2'd2, 1'b1, 0, 2);
      @(negedge clk);
      check_pair(10'h013, 2'd2, 1'b1, 1, 2);
      @(negedge clk);
      chk("R9 valid drops after restarted burst", 32'(valid_o), 32'd0);

      // R10: new start in the last cycle of a two-beat burst
      launch(10'h100, 2'd1, 1'b0);
      chk("R10 first burst last", 32'(last_o), 32'd1);
      launch(10'h202, 2'd2, 1'b0);
      chk("R10 seamless valid", 32'(valid_o), 32'd1);
      check_pair(10'h202, 2'd2, 1'b0, 0, 2);
      @(negedge clk);
      check_pair(10'h202, 2'd2, 1'b0, 1, 2);
      @(negedge clk);
      chk("R10 valid drops", 32'(valid_o), 32'd0);

      // R6: mode and column changes with no strobe leave the block idle
      for (int i = 0; i < 4; i++) begin
         col_i     = 10'(37 * i + 5);
         bl_code_i = 2'(i);
         ilv_i     = i[0];
         @(negedge clk);
         chk("R6 idle valid", 32'(valid_o), 32'd0);
         chk("R6 idle last", 32'(last_o), 32'd0);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule